// File: doc/BRIEF.md
# MOESI Snooping Line Coherence Controller

This block keeps the coherence state of a small set of lines in a write-back cache that snoops a shared bus. Each line holds one of five states: modified, owned, exclusive, shared or invalid. A processor-side port carries reads, writes and evictions for one line index per cycle. A snoop port carries requests that other masters have put on the bus. From the state of the addressed line and the request, the controller picks a bus command. That command can be a read, a read-for-ownership, an upgrade, a write-back to memory, or a cache-to-cache data supply. The line's new state is registered on the next clock edge.

The command and the per-request flags are combinational outputs in the cycle of the request. The bus model answers a read miss with a shared indication in that same cycle, and that answer decides whether the line fills clean-exclusive or shared. A dirty line that another reader requests is supplied cache-to-cache and moves to the owned state, so memory is not written. Memory is written only when a modified or owned line is evicted.

Top module: `moesi_ctrl`

## Requirements
- R1: After reset every line reads invalid on `state_o` and `bus_cmd_o` is 0. The state encoding on `state_o` is invalid=0, shared=1, exclusive=2, owned=3, modified=4.
- R2: A processor read (`pr_op_i`=0) to an invalid line drives bus command BusRd (1). The line becomes exclusive if `shared_i` is 0 in that cycle, and shared if it is 1. `pr_hit_o` stays 0.
- R3: A processor read to a valid line asserts `pr_hit_o`, drives no bus command and leaves the state unchanged.
- R4: A processor write (`pr_op_i`=1) leaves the line modified. From invalid it drives BusRdX (2) with no hit. From shared or owned it drives BusUpgr (3) with a hit. From exclusive or modified it drives no command, with a hit.
- R5: A snooped BusRd (`snp_op_i`=1) turns a modified line to owned and keeps an owned line owned, and in both cases it drives FlushOpt (5). It turns exclusive to shared with no command and leaves shared and invalid lines as they are. For snooped codes 1 to 3, `snp_shared_o` is 1 exactly when the snooped line is valid.
- R6: A snooped BusRdX (2) invalidates the line. A modified or owned line first drives FlushOpt (5). Exclusive and shared lines drive no command.
- R7: A snooped BusUpgr (3) invalidates any valid line and drives no command.
- R8: A snooped Flush (4) or FlushOpt (5) changes no state, drives no command and leaves `snp_shared_o` at 0.
- R9: An eviction (`pr_op_i`=2) invalidates the line. A modified or owned line drives Flush (4). Exclusive, shared and invalid lines drive no command.
- R10: When a snoop and a processor request arrive in the same cycle, only the snoop takes effect. `pr_retry_o` is 1, `pr_hit_o` is 0 and the processor request changes no state.
- R11: A request to one line index leaves the state of every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pr_valid_i | input | 1 | Processor request valid |
| pr_op_i | input | 2 | Processor request: 0 read, 1 write, 2 evict, 3 none |
| pr_idx_i | input | IDX_W | Line index for the processor request, also selects `state_o` |
| pr_hit_o | output | 1 | Processor read or write found a valid line |
| pr_retry_o | output | 1 | Processor request dropped because a snoop took the cycle |
| state_o | output | 3 | Current state of line `pr_idx_i` |
| shared_i | input | 1 | Bus shared response for this cycle's read miss |
| snp_valid_i | input | 1 | Snooped bus request valid |
| snp_op_i | input | 3 | Snooped request: 1 BusRd, 2 BusRdX, 3 BusUpgr, 4 Flush, 5 FlushOpt |
| snp_idx_i | input | IDX_W | Line index of the snooped request |
| snp_shared_o | output | 1 | This cache holds the snooped line valid |
| bus_cmd_o | output | 3 | Bus command issued: 0 none, 1 BusRd, 2 BusRdX, 3 BusUpgr, 4 Flush, 5 FlushOpt |

## Verification
The owned state is the hardest to reach from the ports. Getting there needs a line filled modified, by a write miss or by a silent exclusive upgrade, and then a snooped BusRd. Each way out of owned then has to be checked separately. The stimulus table builds these chains on purpose: owned, then upgrade; owned, then BusRdX; owned, then BusUpgr; owned, then eviction. It also places a snoop in the same cycle as a write to a line, so that the dropped request can be seen on `state_o` a cycle later.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } line_st_e;

  typedef enum logic [1:0] {
    PR_RD    = 2'd0,
    PR_WR    = 2'd1,
    PR_EVICT = 2'd2,
    PR_NOP   = 2'd3
  } pr_op_e;

  // shared by snooped requests and issued commands
  typedef enum logic [2:0] {
    BC_NONE      = 3'd0,
    BC_RD        = 3'd1,
    BC_RDX       = 3'd2,
    BC_UPGR      = 3'd3,
    BC_FLUSH     = 3'd4,
    BC_FLUSH_OPT = 3'd5
  } bus_cmd_e;

  function automatic logic is_dirty(line_st_e s);
    return (s == ST_M) || (s == ST_O);
  endfunction

endpackage

// File: rtl/moesi_next.sv
module moesi_next
  import moesi_pkg::*;
(
  input  line_st_e cur_i,
  input  logic     pr_act_i,
  input  pr_op_e   pr_op_i,
  input  logic     snp_act_i,
  input  bus_cmd_e snp_op_i,
  input  logic     shared_i,
  output line_st_e nxt_o,
  output bus_cmd_e cmd_o,
  output logic     hit_o,
  output logic     snp_shared_o
);

  logic valid_line;
  assign valid_line = (cur_i != ST_I);

  always_comb begin
    nxt_o        = cur_i;
    cmd_o        = BC_NONE;
    hit_o        = 1'b0;
    snp_shared_o = 1'b0;
    if (snp_act_i) begin
      case (snp_op_i)
        BC_RD: begin
          snp_shared_o = valid_line;
          case (cur_i)
            ST_M: begin nxt_o = ST_O; cmd_o = BC_FLUSH_OPT; end
            ST_O: cmd_o = BC_FLUSH_OPT;
            ST_E: nxt_o = ST_S;
            default: ;
          endcase
        end
        BC_RDX: begin
          snp_shared_o = valid_line;
          if (is_dirty(cur_i)) cmd_o = BC_FLUSH_OPT;
          nxt_o = ST_I;
        end
        BC_UPGR: begin
          snp_shared_o = valid_line;
          nxt_o = ST_I;
        end
        default: ;  // foreign write-backs leave the line alone
      endcase
    end else if (pr_act_i) begin
      case (pr_op_i)
        PR_RD: begin
          if (valid_line) hit_o = 1'b1;
          else begin
            cmd_o = BC_RD;
            nxt_o = shared_i ? ST_S : ST_E;
          end
        end
        PR_WR: begin
          hit_o = valid_line;
          case (cur_i)
            ST_I:       cmd_o = BC_RDX;
            ST_S, ST_O: cmd_o = BC_UPGR;
            default: ;
          endcase
          nxt_o = ST_M;
        end
        PR_EVICT: begin
          if (is_dirty(cur_i)) cmd_o = BC_FLUSH;
          nxt_o = ST_I;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/moesi_line.sv
module moesi_line
  import moesi_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  line_st_e nxt_i,
  input  logic     pr_sel_i,
  input  pr_op_e   pr_op_i,
  input  logic     snp_sel_i,
  input  bus_cmd_e snp_op_i,
  output line_st_e state_o
);

  line_st_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   state_q <= ST_I;
    else if (we_i) state_q <= nxt_i;
  end

  assign state_o = state_q;

  assert_legal_state_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q inside {ST_I, ST_S, ST_E, ST_O, ST_M});

  assert_write_mod_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pr_sel_i && pr_op_i == PR_WR) |=> state_q == ST_M);

  assert_rd_keeps_owner_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_sel_i && snp_op_i == BC_RD && is_dirty(state_q)) |=> state_q == ST_O);

  assert_rdx_inval_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_sel_i && snp_op_i == BC_RDX) |=> state_q == ST_I);

  assert_upgr_inval_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_sel_i && snp_op_i == BC_UPGR) |=> state_q == ST_I);

  assert_evict_inval_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pr_sel_i && pr_op_i == PR_EVICT) |=> state_q == ST_I);

  assert_unselected_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pr_sel_i && !snp_sel_i) |=> $stable(state_q));

endmodule

// File: rtl/moesi_ctrl.sv
module moesi_ctrl
  import moesi_pkg::*;
#(
  parameter int NUM_LINES = 4,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pr_valid_i,
  input  logic [1:0]       pr_op_i,
  input  logic [IDX_W-1:0] pr_idx_i,
  output logic             pr_hit_o,
  output logic             pr_retry_o,
  output logic [2:0]       state_o,
  input  logic             shared_i,
  input  logic             snp_valid_i,
  input  logic [2:0]       snp_op_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  output logic             snp_shared_o,
  output logic [2:0]       bus_cmd_o
);

  line_st_e         st_q [NUM_LINES];
  line_st_e         cur_st, nxt_st;
  bus_cmd_e         cmd, snp_op;
  pr_op_e           pr_op;
  logic             pr_act, upd;
  logic [IDX_W-1:0] sel_idx;

  assign pr_op   = pr_op_e'(pr_op_i);
  assign snp_op  = bus_cmd_e'(snp_op_i);
  // a snoop owns the bus this cycle; the processor must reissue
  assign pr_act  = pr_valid_i && !snp_valid_i;
  assign upd     = pr_act || snp_valid_i;
  assign sel_idx = snp_valid_i ? snp_idx_i : pr_idx_i;
  assign cur_st  = st_q[sel_idx];

  moesi_next u_next (
    .cur_i        (cur_st),
    .pr_act_i     (pr_act),
    .pr_op_i      (pr_op),
    .snp_act_i    (snp_valid_i),
    .snp_op_i     (snp_op),
    .shared_i     (shared_i),
    .nxt_o        (nxt_st),
    .cmd_o        (cmd),
    .hit_o        (pr_hit_o),
    .snp_shared_o (snp_shared_o)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic pr_sel, snp_sel;
    assign pr_sel  = pr_act && (pr_idx_i == IDX_W'(g));
    assign snp_sel = snp_valid_i && (snp_idx_i == IDX_W'(g));

    moesi_line u_line (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (upd && (sel_idx == IDX_W'(g))),
      .nxt_i     (nxt_st),
      .pr_sel_i  (pr_sel),
      .pr_op_i   (pr_op),
      .snp_sel_i (snp_sel),
      .snp_op_i  (snp_op),
      .state_o   (st_q[g])
    );
  end

  assign bus_cmd_o  = cmd;
  assign pr_retry_o = pr_valid_i && snp_valid_i;
  assign state_o    = st_q[pr_idx_i];

  assert_supply_on_snoop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == BC_FLUSH_OPT) |-> (snp_valid_i && snp_op inside {BC_RD, BC_RDX}));

  assert_retry_no_own_cmd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pr_retry_o |-> (bus_cmd_o inside {BC_NONE, BC_FLUSH_OPT} && !pr_hit_o));

  assert_flush_on_evict_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o == BC_FLUSH) |-> (pr_valid_i && pr_op == PR_EVICT));

endmodule

// File: tb/moesi_ctrl_bench.sv
`timescale 1ns/1ps
module moesi_ctrl_bench;

  localparam int I = 0, S = 1, E = 2, O = 3, M = 4;
  localparam int RD = 0, WR = 1, EV = 2;
  localparam int NO = 0, BRD = 1, BRDX = 2, BUP = 3, BFL = 4, BFO = 5;

  typedef struct packed {
    logic       pv;
    logic [1:0] pop;
    logic [1:0] pidx;
    logic       sv;
    logic [2:0] sop;
    logic [1:0] sidx;
    logic       sh;
    logic [2:0] ecmd;
    logic       ehit;
    logic       eretry;
    logic       esh;
    logic [1:0] cidx;
    logic [2:0] est;
    logic [3:0] req;
  } vec_t;

  function automatic vec_t v(int pv, int pop, int pidx, int sv, int sop, int sidx, int sh,
                             int ecmd, int ehit, int eretry, int esh, int cidx, int est,
                             int req);
    vec_t r;
    r.pv = 1'(pv);     r.pop = 2'(pop);   r.pidx = 2'(pidx);
    r.sv = 1'(sv);     r.sop = 3'(sop);   r.sidx = 2'(sidx);  r.sh = 1'(sh);
    r.ecmd = 3'(ecmd); r.ehit = 1'(ehit); r.eretry = 1'(eretry); r.esh = 1'(esh);
    r.cidx = 2'(cidx); r.est = 3'(est);   r.req = 4'(req);
    return r;
  endfunction

  localparam int NV = 40;
  localparam vec_t TBL [NV] = '{
    v(1,RD,0, 0,0,0, 0, BRD,0,0,0, 0,E, 2),   // R2 miss, no sharer
    v(1,RD,0, 0,0,0, 0, NO,1,0,0,  0,E, 3),   // R3 hit on E
    v(1,WR,0, 0,0,0, 0, NO,1,0,0,  0,M, 4),   // R4 silent E->M
    v(0,0,0,  1,BRD,0,0, BFO,0,0,1, 0,O, 5),  // R5 M->O supply
    v(0,0,0,  1,BRD,0,0, BFO,0,0,1, 0,O, 5),  // R5 O stays, supplies
    v(1,RD,0, 0,0,0, 0, NO,1,0,0,  0,O, 3),   // R3 hit on O
    v(1,WR,0, 0,0,0, 0, BUP,1,0,0, 0,M, 4),   // R4 O->M upgrade
    v(1,RD,1, 0,0,0, 1, BRD,0,0,0, 1,S, 2),   // R2 miss with sharer
    v(0,0,0,  1,BRD,1,0, NO,0,0,1, 1,S, 5),   // R5 S stays
    v(1,WR,1, 0,0,0, 0, BUP,1,0,0, 1,M, 4),   // R4 S->M upgrade
    v(0,0,0,  1,BRDX,1,0, BFO,0,0,1, 1,I, 6), // R6 M supplies then I
    v(1,WR,2, 0,0,0, 0, BRDX,0,0,0, 2,M, 4),  // R4 write miss
    v(1,EV,2, 0,0,0, 0, BFL,0,0,0, 2,I, 9),   // R9 evict M
    v(1,RD,2, 0,0,0, 0, BRD,0,0,0, 2,E, 2),   // R2
    v(0,0,0,  1,BRD,2,0, NO,0,0,1, 2,S, 5),   // R5 E->S silent
    v(0,0,0,  1,BUP,2,0, NO,0,0,1, 2,I, 7),   // R7 S invalidated
    v(0,0,0,  1,BFL,0,0, NO,0,0,0, 0,M, 8),   // R8 foreign Flush
    v(0,0,0,  1,BFO,0,0, NO,0,0,0, 0,M, 8),   // R8 foreign FlushOpt
    v(1,WR,3, 1,BRD,0,0, BFO,0,1,1, 0,O, 10), // R10 snoop wins
    v(0,0,0,  0,0,0, 0, NO,0,0,0,  3,I, 10),  // R10 dropped write left no trace
    v(0,0,0,  1,BRDX,0,0, BFO,0,0,1, 0,I, 6), // R6 O supplies then I
    v(1,RD,3, 0,0,0, 0, BRD,0,0,0, 3,E, 2),   // R2
    v(0,0,0,  1,BRDX,3,0, NO,0,0,1, 3,I, 6),  // R6 E invalidated
    v(1,WR,1, 0,0,0, 0, BRDX,0,0,0, 1,M, 4),  // R4
    v(0,0,0,  1,BRD,1,0, BFO,0,0,1, 1,O, 5),  // R5
    v(0,0,0,  1,BUP,1,0, NO,0,0,1, 1,I, 7),   // R7 O invalidated
    v(1,WR,0, 0,0,0, 0, BRDX,0,0,0, 0,M, 4),  // R4
    v(0,0,0,  1,BRD,0,0, BFO,0,0,1, 0,O, 5),  // R5
    v(1,EV,0, 0,0,0, 0, BFL,0,0,0, 0,I, 9),   // R9 evict O
    v(1,RD,2, 0,0,0, 1, BRD,0,0,0, 2,S, 2),   // R2
    v(1,EV,2, 0,0,0, 0, NO,0,0,0,  2,I, 9),   // R9 evict S silent
    v(0,0,0,  1,BRD,3,0, NO,0,0,0, 3,I, 5),   // R5 snoop to I line
    v(1,EV,3, 0,0,0, 0, NO,0,0,0,  3,I, 9),   // R9 evict I
    v(1,RD,3, 0,0,0, 0, BRD,0,0,0, 3,E, 2),   // R2
    v(1,WR,2, 0,0,0, 0, BRDX,0,0,0, 3,E, 11), // R11 other line untouched
    v(0,0,0,  1,BRDX,2,0, BFO,0,0,1, 3,E, 11),// R11
    v(1,RD,1, 0,0,0, 1, BRD,0,0,0, 1,S, 2),   // R2
    v(1,EV,3, 0,0,0, 0, NO,0,0,0,  1,S, 11),  // R11 evict E elsewhere
    v(1,WR,1, 1,BRD,1,0, NO,0,1,1, 1,S, 10),  // R10 write to S dropped
    v(1,EV,1, 1,BFL,0,0, NO,0,1,0, 1,S, 10)   // R10 evict dropped
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pr_valid_i = 1'b0;
  logic [1:0] pr_op_i = '0;
  logic [1:0] pr_idx_i = '0;
  logic       pr_hit_o, pr_retry_o, snp_shared_o;
  logic [2:0] state_o, bus_cmd_o;
  logic       shared_i = 1'b0;
  logic       snp_valid_i = 1'b0;
  logic [2:0] snp_op_i = '0;
  logic [1:0] snp_idx_i = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  moesi_ctrl #(.NUM_LINES(4)) u_moesi_ctrl (
    .clk_i, .rst_ni, .pr_valid_i, .pr_op_i, .pr_idx_i, .pr_hit_o, .pr_retry_o,
    .state_o, .shared_i, .snp_valid_i, .snp_op_i, .snp_idx_i, .snp_shared_o, .bus_cmd_o
  );

  task automatic chk(int req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic go_idle(int idx);
    pr_valid_i = 1'b0; snp_valid_i = 1'b0; shared_i = 1'b0;
    pr_op_i = 2'd3; snp_op_i = '0; pr_idx_i = 2'(idx);
  endtask

  task automatic check_all_invalid(int req);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i); go_idle(k); #1;
      chk(req, $sformatf("state of line %0d after reset", k), int'(state_o), I);
      chk(req, "bus command after reset", int'(bus_cmd_o), NO);
    end
  endtask

  task automatic apply(vec_t t);
    @(negedge clk_i);
    pr_valid_i = t.pv; pr_op_i = t.pop; pr_idx_i = t.pidx;
    snp_valid_i = t.sv; snp_op_i = t.sop; snp_idx_i = t.sidx; shared_i = t.sh;
    #1;
    chk(int'(t.req), "bus_cmd_o",    int'(bus_cmd_o),    int'(t.ecmd));
    chk(int'(t.req), "pr_hit_o",     int'(pr_hit_o),     int'(t.ehit));
    chk(int'(t.req), "pr_retry_o",   int'(pr_retry_o),   int'(t.eretry));
    chk(int'(t.req), "snp_shared_o", int'(snp_shared_o), int'(t.esh));
    @(negedge clk_i);
    go_idle(int'(t.cidx));
    #1;
    chk(int'(t.req), $sformatf("state_o of line %0d", t.cidx), int'(state_o), int'(t.est));
  endtask

  initial begin
    go_idle(0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check_all_invalid(1);  // R1 initial reset state
    for (int n = 0; n < NV; n++) apply(TBL[n]);
    // R1 asynchronous reset mid-run: line 1 holds S here
    @(negedge clk_i); rst_ni = 1'b0;
    #1 chk(1, "state_o during reset", int'(state_o), I);
    @(negedge clk_i); rst_ni = 1'b1;
    check_all_invalid(1);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule